// File: doc/BRIEF.md
# NTT Polynomial Multiplier

This block computes the full linear product of two polynomials. Each operand has `N_COEF` coefficients in the range 0 to q−1, and all arithmetic is modulo a small prime q. Each operand is zero-padded to `N_PT = 2·N_COEF` points and goes through a forward number theoretic transform built on an `N_PT`-th primitive root of unity mod q. The two spectra are multiplied point by point, and an inverse transform with the inverse root, scaled by `N_PT⁻¹ mod q`, returns the `2·N_COEF − 1` product coefficients. A single combinational butterfly computes `t + u·ω` and `t − u·ω`. It serves every stage of every transform, and its multiplier also does the pointwise products and the final scaling.

Operands enter through a valid/ready port. Each beat carries one coefficient of each operand. The product leaves one coefficient per beat through a second valid/ready port. The block takes no new operands between the last input beat and the end of the result stream. A one-cycle `done` pulse closes each operation. The default configuration is `N_COEF = 16`, `N_PT = 32` and `q = 7681`.

Top module: `ntt_polymul`

## Requirements
- R1: In reset and right after it, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: An operation accepts exactly `N_COEF` input beats. Beat i (i = 0, 1, …, N_COEF−1) carries a_i on `in_a` and b_i on `in_b`. After the last beat is accepted, `in_ready` is 0 in the next cycle.
- R3: From the last accepted input beat until the cycle after `done`, `in_ready` stays 0, and `in_valid` with any data has no effect on the result.
- R4: The output stream has exactly `2·N_COEF−1` beats. Beat k (k = 0 upward) carries c_k = Σ a_i·b_j mod q over all i + j = k, with q = 7681 by default. Input coefficients must be below q.
- R5: Every output value lies in 0..q−1, including for operands whose coefficients all equal q−1.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` keeps its value in the next cycle.
- R7: `done` is 1 for exactly one cycle: the cycle after the final output handshake. `in_ready` is 1 again in the cycle after that.
- R8: An operation's result depends only on its own operands. For example, all-zero operands following nonzero ones give an all-zero product.
- R9: `out_valid` first rises exactly `3·(N_PT/2)·log2(N_PT) + 2·N_PT` clock cycles after the edge that accepts the final input beat. This is 304 cycles by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block accepts an input beat |
| in_a | input | W | Coefficient of the first operand |
| in_b | input | W | Coefficient of the second operand |
| out_valid | output | 1 | Product coefficient available |
| out_ready | input | 1 | Consumer takes the product coefficient |
| out_data | output | W | Product coefficient, lowest degree first |
| done | output | 1 | One-cycle pulse after the final output beat |

## Verification
Both transforms spread every stored value over all points. A bad twiddle, a wrong butterfly address or a missed reduction therefore corrupts most of the product coefficients, and the error appears on the first output beat after the fixed latency. A counter or stage-sequencing fault shows up either as a shifted first-valid cycle or as a wrong number of output beats. Stale memory contents show up as a nonzero result for zero operands in the following operation. The sweep places a single term at every degree of one operand, which exercises each bit-reversed load address and every output position.

// File: rtl/ntt_pkg.sv
package ntt_pkg;

   typedef enum logic [2:0] {
      PH_LOAD,
      PH_FWD_A,
      PH_FWD_B,
      PH_PMUL,
      PH_PERM,
      PH_INV,
      PH_UNLOAD,
      PH_DONE
   } phase_t;

   // Square-and-multiply modular exponentiation for elaboration-time constants
   function automatic longint unsigned mod_pow(input longint unsigned base,
                                               input longint unsigned expo,
                                               input longint unsigned m);
      longint unsigned r;
      longint unsigned bb;
      longint unsigned ee;
      r  = 1;
      bb = base % m;
      ee = expo;
      while (ee != 0) begin
         if (ee[0]) r = (r * bb) % m;
         bb = (bb * bb) % m;
         ee = ee >> 1;
      end
      return r;
   endfunction

   // Finds an element of multiplicative order exactly npt (npt a power of two)
   function automatic longint unsigned find_root(input longint unsigned m,
                                                 input longint unsigned npt);
      longint unsigned r;
      longint unsigned h;
      r = 0;
      for (longint unsigned x = 2; (x < m) && (r == 0); x++) begin
         h = mod_pow(x, (m - 1) / npt, m);
         if (mod_pow(h, npt / 2, m) == m - 1) r = h;
      end
      return r;
   endfunction

endpackage

// File: rtl/ntt_modmul.sv
module ntt_modmul #(
   parameter int W = 13,
   parameter int Q = 7681,
   parameter bit USE_BARRETT = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] p
);
   localparam int PW = 2 * W;
   localparam int MW = W + 2;

   logic [PW-1:0] x;
   assign x = PW'(a) * PW'(b);

   generate
      if (USE_BARRETT) begin : g_barrett
         localparam int BK = PW;
         localparam logic [MW-1:0] BM = MW'((64'd1 << BK) / 64'(Q));
         logic [PW+MW-1:0] xm;
         logic [MW-1:0]    qt;
         logic [PW-1:0]    r0;
         logic [PW-1:0]    r1;
         logic [PW-1:0]    r2;
         assign xm = (PW+MW)'(x) * (PW+MW)'(BM);
         assign qt = MW'(xm >> BK);
         // Estimated quotient is low by at most two, so r0 < 3q
         assign r0 = x - PW'(qt) * PW'(Q);
         assign r1 = (r0 >= PW'(Q)) ? r0 - PW'(Q) : r0;
         assign r2 = (r1 >= PW'(Q)) ? r1 - PW'(Q) : r1;
         assign p  = W'(r2);
      end else begin : g_direct
         assign p = W'(x % PW'(Q));
      end
   endgenerate
endmodule

// File: rtl/ntt_butterfly.sv
module ntt_butterfly #(
   parameter int W = 13,
   parameter int Q = 7681,
   parameter bit USE_BARRETT = 1'b1
) (
   input  logic [W-1:0] t,
   input  logic [W-1:0] u,
   input  logic [W-1:0] w,
   output logic [W-1:0] sum,
   output logic [W-1:0] diff
);
   logic [W-1:0] prod;
   logic [W:0]   s_raw;
   logic [W:0]   d_raw;

   ntt_modmul #(.W(W), .Q(Q), .USE_BARRETT(USE_BARRETT)) mul_i (
      .a(u),
      .b(w),
      .p(prod)
   );

   assign s_raw = {1'b0, t} + {1'b0, prod};
   // q is added first so the difference never goes below zero
   assign d_raw = {1'b0, t} + (W+1)'(Q) - {1'b0, prod};
   assign sum   = (s_raw >= (W+1)'(Q)) ? W'(s_raw - (W+1)'(Q)) : W'(s_raw);
   assign diff  = (d_raw >= (W+1)'(Q)) ? W'(d_raw - (W+1)'(Q)) : W'(d_raw);
endmodule

// File: rtl/ntt_twiddle_rom.sv
module ntt_twiddle_rom #(
   parameter int W = 13,
   parameter int N_PT = 32,
   parameter int Q = 7681,
   localparam int IW = $clog2(N_PT) - 1
) (
   input  logic [IW-1:0] idx,
   input  logic          inv,
   output logic [W-1:0]  w
);
   localparam int HALF = N_PT / 2;
   localparam longint unsigned ROOT     = ntt_pkg::find_root(64'(Q), 64'(N_PT));
   localparam longint unsigned ROOT_INV = ntt_pkg::mod_pow(ROOT, 64'(N_PT - 1), 64'(Q));

   if (ROOT == 0) begin : g_no_root
      $fatal(1, "no primitive root of the requested order exists for this modulus");
   end

   logic [W-1:0] fwd_tab [HALF];
   logic [W-1:0] inv_tab [HALF];

   for (genvar gi = 0; gi < HALF; gi++) begin : g_tab
      assign fwd_tab[gi] = W'(ntt_pkg::mod_pow(ROOT, 64'(gi), 64'(Q)));
      assign inv_tab[gi] = W'(ntt_pkg::mod_pow(ROOT_INV, 64'(gi), 64'(Q)));
   end

   assign w = inv ? inv_tab[idx] : fwd_tab[idx];
endmodule

// File: rtl/ntt_regfile.sv
module ntt_regfile #(
   parameter int W = 13,
   parameter int DEPTH = 32,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we0,
   input  logic [AW-1:0] wa0,
   input  logic [W-1:0]  wd0,
   input  logic          we1,
   input  logic [AW-1:0] wa1,
   input  logic [W-1:0]  wd1,
   input  logic [AW-1:0] ra0,
   input  logic [AW-1:0] ra1,
   output logic [W-1:0]  rd0,
   output logic [W-1:0]  rd1
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (we0) mem[wa0] <= wd0;
         if (we1) mem[wa1] <= wd1;
      end
   end

   assign rd0 = mem[ra0];
   assign rd1 = mem[ra1];

   // R4: the two write ports never target one entry in the same cycle
   assert_port_conflict_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we0 && we1) |-> (wa0 != wa1));
endmodule

// File: rtl/ntt_polymul.sv
module ntt_polymul #(
   parameter int W = 13,
   parameter int N_COEF = 16,
   parameter int Q = 7681,
   parameter bit REDUCE_BARRETT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data,
   output logic         done
);
   import ntt_pkg::*;

   localparam int N_PT    = 2 * N_COEF;
   localparam int LOGN    = $clog2(N_PT);
   localparam int IW      = LOGN - 1;
   localparam int HALF    = N_PT / 2;
   localparam int SW      = $clog2(LOGN);
   localparam int OUT_CNT = 2 * N_COEF - 1;
   localparam logic [W-1:0] NINV = W'(mod_pow(64'(N_PT), 64'(Q - 2), 64'(Q)));

   if (N_COEF < 2 || (N_COEF & (N_COEF - 1)) != 0) begin : g_bad_n
      $fatal(1, "N_COEF must be a power of two of at least 2");
   end
   if (Q >= (1 << W) || Q < 3) begin : g_bad_q
      $fatal(1, "modulus does not fit the coefficient width");
   end
   if (((Q - 1) % N_PT) != 0) begin : g_bad_order
      $fatal(1, "q-1 must be divisible by the transform length");
   end

   function automatic logic [LOGN-1:0] bit_rev(input logic [LOGN-1:0] x);
      logic [LOGN-1:0] r;
      for (int i = 0; i < LOGN; i++) r[i] = x[LOGN-1-i];
      return r;
   endfunction

   phase_t          phase;
   logic [LOGN-1:0] cnt;
   logic [SW-1:0]   stage;

   logic in_fire;
   logic out_fire;
   logic ntt_active;
   assign in_fire    = in_valid && in_ready;
   assign out_fire   = out_valid && out_ready;
   assign ntt_active = (phase == PH_FWD_A) || (phase == PH_FWD_B) || (phase == PH_INV);

   // butterfly address generation (decimation in time, bit-reversed input)
   logic [LOGN-1:0] jmask;
   logic [LOGN-1:0] jpart;
   logic [LOGN-1:0] top_a;
   logic [LOGN-1:0] bot_a;
   logic [LOGN-1:0] rev_cnt;
   logic [IW-1:0]   tw_idx;
   logic [W-1:0]    tw;

   assign jmask   = (LOGN'(1) << stage) - LOGN'(1);
   assign jpart   = cnt & jmask;
   assign top_a   = ((cnt >> stage) << (int'(stage) + 1)) | jpart;
   assign bot_a   = top_a | (LOGN'(1) << stage);
   assign rev_cnt = bit_rev(cnt);
   assign tw_idx  = IW'(jpart << (LOGN - 1 - int'(stage)));

   ntt_twiddle_rom #(.W(W), .N_PT(N_PT), .Q(Q)) rom_i (
      .idx(tw_idx),
      .inv(phase == PH_INV),
      .w  (tw)
   );

   // memories
   logic [LOGN-1:0] ra0, ra1;
   logic [W-1:0]    a_rd0, a_rd1, b_rd0, b_rd1;
   logic            a_we0, a_we1, b_we0, b_we1;
   logic [LOGN-1:0] a_wa0, a_wa1, b_wa0, b_wa1;
   logic [W-1:0]    a_wd0, a_wd1, b_wd0, b_wd1;
   logic            mem_clr;

   assign ra0     = ntt_active ? top_a : cnt;
   assign ra1     = ntt_active ? bot_a : rev_cnt;
   assign mem_clr = (phase == PH_DONE);

   ntt_regfile #(.W(W), .DEPTH(N_PT)) bank_a_i (
      .clk(clk), .rst_n(rst_n), .clr(mem_clr),
      .we0(a_we0), .wa0(a_wa0), .wd0(a_wd0),
      .we1(a_we1), .wa1(a_wa1), .wd1(a_wd1),
      .ra0(ra0), .ra1(ra1), .rd0(a_rd0), .rd1(a_rd1)
   );

   ntt_regfile #(.W(W), .DEPTH(N_PT)) bank_b_i (
      .clk(clk), .rst_n(rst_n), .clr(mem_clr),
      .we0(b_we0), .wa0(b_wa0), .wd0(b_wd0),
      .we1(b_we1), .wa1(b_wa1), .wd1(b_wd1),
      .ra0(ra0), .ra1(ra1), .rd0(b_rd0), .rd1(b_rd1)
   );

   // shared arithmetic core
   logic [W-1:0] bf_t, bf_u, bf_w, bf_sum, bf_diff;

   always_comb begin
      bf_t = a_rd0;
      bf_u = a_rd1;
      bf_w = tw;
      case (phase)
         PH_FWD_B: begin
            bf_t = b_rd0;
            bf_u = b_rd1;
         end
         PH_PMUL: begin
            bf_t = '0;
            bf_u = a_rd0;
            bf_w = b_rd0;
         end
         PH_UNLOAD: begin
            bf_t = '0;
            bf_u = a_rd0;
            bf_w = NINV;
         end
         default: ;
      endcase
   end

   ntt_butterfly #(.W(W), .Q(Q), .USE_BARRETT(REDUCE_BARRETT)) bf_i (
      .t(bf_t), .u(bf_u), .w(bf_w), .sum(bf_sum), .diff(bf_diff)
   );

   // write steering
   always_comb begin
      a_we0 = 1'b0;  a_we1 = 1'b0;  b_we0 = 1'b0;  b_we1 = 1'b0;
      a_wa0 = ra0;   a_wa1 = ra1;   b_wa0 = ra0;   b_wa1 = ra1;
      a_wd0 = bf_sum; a_wd1 = bf_diff; b_wd0 = bf_sum; b_wd1 = bf_diff;
      case (phase)
         PH_LOAD: begin
            a_we0 = in_fire;
            b_we0 = in_fire;
            a_wa0 = rev_cnt;
            b_wa0 = rev_cnt;
            a_wd0 = in_a;
            b_wd0 = in_b;
         end
         PH_FWD_A, PH_INV: begin
            a_we0 = 1'b1;
            a_we1 = 1'b1;
         end
         PH_FWD_B: begin
            b_we0 = 1'b1;
            b_we1 = 1'b1;
         end
         PH_PMUL: a_we0 = 1'b1;
         PH_PERM: begin
            a_we0 = (cnt < rev_cnt);
            a_we1 = (cnt < rev_cnt);
            a_wd0 = a_rd1;
            a_wd1 = a_rd0;
         end
         default: ;
      endcase
   end

   // sequencing
   phase_t ntt_next;
   always_comb begin
      case (phase)
         PH_FWD_A: ntt_next = PH_FWD_B;
         PH_FWD_B: ntt_next = PH_PMUL;
         default:  ntt_next = PH_UNLOAD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_LOAD;
         cnt   <= '0;
         stage <= '0;
      end else begin
         case (phase)
            PH_LOAD: begin
               if (in_fire) begin
                  if (cnt == LOGN'(N_COEF - 1)) begin
                     phase <= PH_FWD_A;
                     cnt   <= '0;
                     stage <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            PH_FWD_A, PH_FWD_B, PH_INV: begin
               if (cnt == LOGN'(HALF - 1)) begin
                  cnt <= '0;
                  if (stage == SW'(LOGN - 1)) begin
                     stage <= '0;
                     phase <= ntt_next;
                  end else begin
                     stage <= stage + 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_PMUL: begin
               cnt <= cnt + 1'b1;
               if (cnt == LOGN'(N_PT - 1)) phase <= PH_PERM;
            end
            PH_PERM: begin
               cnt <= cnt + 1'b1;
               if (cnt == LOGN'(N_PT - 1)) phase <= PH_INV;
            end
            PH_UNLOAD: begin
               if (out_fire) begin
                  if (cnt == LOGN'(OUT_CNT - 1)) begin
                     phase <= PH_DONE;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: begin
               phase <= PH_LOAD;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign in_ready  = (phase == PH_LOAD);
   assign out_valid = (phase == PH_UNLOAD);
   assign out_data  = bf_sum;
   assign done      = (phase == PH_DONE);

   // R2: the final input beat closes the input port
   assert_load_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fire && cnt == LOGN'(N_COEF - 1)) |=> !in_ready);

   // R4: operands are expected already reduced
   assert_input_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_fire |-> (in_a < W'(Q) && in_b < W'(Q)));

   // R5: butterfly results stay reduced during every transform stage
   assert_bf_reduced_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ntt_active |-> (bf_sum < W'(Q) && bf_diff < W'(Q)));

   // R5: emitted coefficients are reduced
   assert_out_reduced_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data < W'(Q)));

   // R6: a stalled output beat is held
   assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R7: done is a single pulse followed by an open input port
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && in_ready));
endmodule

// File: tb/ntt_polymul_tb.sv
module ntt_polymul_tb_top;
   localparam int W    = 13;
   localparam int NC   = 16;
   localparam int Q    = 7681;
   localparam int NOUT = 2 * NC - 1;
   localparam int LAT  = 3 * NC * 5 + 4 * NC;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic         in_ready;
   logic [W-1:0] in_a;
   logic [W-1:0] in_b;
   logic         out_valid;
   logic         out_ready;
   logic [W-1:0] out_data;
   logic         done;

   always #5 clk = ~clk;

   ntt_polymul #(.W(W), .N_COEF(NC), .Q(Q)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .done(done)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int av [NC];
   int bv [NC];
   int expv [NOUT];
   int unsigned seed = 32'h1234_5678;

   task automatic check(input bit ok, input string req, input int act, input int exp_val);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_val);
      end
   endtask

   function automatic int rnd_coef();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 8) % Q);
   endfunction

   task automatic build_expected();
      for (int k = 0; k < NOUT; k++) expv[k] = 0;
      for (int i = 0; i < NC; i++)
         for (int j = 0; j < NC; j++)
            expv[i + j] = int'((longint'(expv[i + j]) + longint'(av[i]) * longint'(bv[j])) % Q);
   endtask

   function automatic bit ready_pat(input int mode, input int cyc);
      case (mode)
         1:       return (cyc % 2) == 0;
         2:       return (cyc % 3) == 2;
         default: return 1'b1;
      endcase
   endfunction

   task automatic run_op(input int stall_mode, input bit poke);
      int lat;
      int busy_bad;
      int k;
      int cyc;
      bit prev_stall;
      int prev_data;
      build_expected();
      // R2: load one coefficient pair per beat
      for (int i = 0; i < NC; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_a = W'(av[i]);
         in_b = W'(bv[i]);
         check(in_ready == 1'b1, "R2 ready during load", int'(in_ready), 1);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      check(in_ready == 1'b0, "R2 closed after last beat", int'(in_ready), 0);
      // R9 latency, R3 refusal while busy
      lat = 0;
      busy_bad = 0;
      while (!out_valid && lat < 2000) begin
         if (poke) begin
            in_valid = 1'b1;
            in_a = W'(rnd_coef());
            in_b = W'(rnd_coef());
         end
         if (in_ready) busy_bad++;
         @(posedge clk);
         lat++;
         @(negedge clk);
      end
      check(lat == LAT, "R9 latency", lat, LAT);
      check(busy_bad == 0, "R3 in_ready while computing", busy_bad, 0);
      // unload
      k = 0;
      cyc = 0;
      prev_stall = 1'b0;
      prev_data = 0;
      while (k < NOUT && cyc < 1000) begin
         if (cyc != 0) @(negedge clk);
         cyc++;
         if (in_ready) busy_bad++;
         if (prev_stall)
            check(out_valid && int'(out_data) == prev_data, "R6 hold under stall",
                  int'(out_data), prev_data);
         out_ready = ready_pat(stall_mode, cyc);
         if (out_valid && out_ready) begin
            check(int'(out_data) == expv[k], $sformatf("R4 coefficient %0d", k),
                  int'(out_data), expv[k]);
            check(int'(out_data) < Q, "R5 reduced output", int'(out_data), Q - 1);
            k++;
            prev_stall = 1'b0;
         end else begin
            prev_stall = out_valid;
            prev_data = int'(out_data);
         end
      end
      check(busy_bad == 0, "R3 in_ready while unloading", busy_bad, 0);
      @(negedge clk);
      out_ready = 1'b0;
      check(done == 1'b1, "R7 done after last beat", int'(done), 1);
      check(out_valid == 1'b0, "R4 no extra beat", int'(out_valid), 0);
      check(in_ready == 1'b0, "R3 closed during done", int'(in_ready), 0);
      @(negedge clk);
      in_valid = 1'b0;
      check(done == 1'b0, "R7 done is one cycle", int'(done), 0);
      check(in_ready == 1'b1, "R7 ready again", int'(in_ready), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      in_valid = 1'b0;
      in_a = '0;
      in_b = '0;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
      check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
      check(done == 1'b0, "R1 done", int'(done), 0);

      // impulse times ramp
      for (int i = 0; i < NC; i++) begin av[i] = (i == 0) ? 1 : 0; bv[i] = i + 1; end
      run_op(0, 1'b0);

      // R5 all coefficients at q-1, with stalls and busy pokes
      for (int i = 0; i < NC; i++) begin av[i] = Q - 1; bv[i] = Q - 1; end
      run_op(1, 1'b1);

      // ramp against descending boundary values
      for (int i = 0; i < NC; i++) begin av[i] = i; bv[i] = Q - 1 - i; end
      run_op(2, 1'b0);

      // R8 zeros after nonzero operands
      for (int i = 0; i < NC; i++) begin av[i] = 0; bv[i] = 0; end
      run_op(0, 1'b1);

      // sweep: single term at every degree against random operand
      for (int p = 0; p < NC; p++) begin
         for (int i = 0; i < NC; i++) begin
            av[i] = (i == p) ? (Q - 1 - p) : 0;
            bv[i] = rnd_coef();
         end
         run_op(p % 3, p[0]);
      end

      // random dense operands
      for (int r = 0; r < 6; r++) begin
         for (int i = 0; i < NC; i++) begin av[i] = rnd_coef(); bv[i] = rnd_coef(); end
         run_op(r % 3, r[0]);
      end

      // R8 zeros again after dense random
      for (int i = 0; i < NC; i++) begin av[i] = 0; bv[i] = 0; end
      run_op(2, 1'b1);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule